// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Word Unit

This block keeps the 16-bit status word and the 16-bit control word of a floating-point coprocessor. Execution units report exceptions as one-cycle pulses. The block holds each of the six exception flags until software clears them. It holds a stack-fault flag that always comes with an invalid-operation flag. It also holds the condition codes, the top-of-stack pointer and a live busy indication. It derives an error-summary bit from the flags that the control word leaves unmasked.

The control word carries the six exception masks together with the precision, rounding and infinity fields. It is written by a load command. The status word is always visible on a 16-bit read bus. Three host flags expose the condition codes in the form that a host's carry, parity and zero flags expect.

Top module: `fpu_exc_status`

## Requirements
- R1: After reset the status word reads 16'h0000, the control word reads 16'h037F and all three host flags are 0.
- R2: Each exception flag is sticky. A one-cycle pulse on `exc_rpt` sets it at the next clock edge, and it then stays set until a clear. The bit order of `exc_rpt` and of status bits 5:0 is: bit0 invalid, bit1 denormal, bit2 zero-divide, bit3 overflow, bit4 underflow, bit5 precision.
- R3: A pulse on `stk_fault` sets status bit 6 (stack fault) and status bit 0 (invalid) together.
- R4: Status bit 7 (error summary) is 1 exactly when some flag in bits 5:0 is set and the matching control bit 5:0 is 0. It follows a control-word load in the same cycle that the new control word appears.
- R5: `exc_clr` clears bits 7:0 at the next edge. A report in the same cycle as a clear still sets its flag.
- R6: `cw_load` writes the control word at the next edge. Only bits 12:8 (infinity, rounding, precision) and bits 5:0 (masks) are writable. Bit 6 always reads 1, and bits 7 and 15:13 always read 0.
- R7: `cc_we` loads `cc_in` into the condition codes: C0 at status bit 8, C1 at bit 9, C2 at bit 10 and C3 at bit 14. Without `cc_we` the codes hold.
- R8: `top_we` loads `top_in` into status bits 13:11. Without `top_we` the field holds.
- R9: Status bit 15 follows `busy_in` in the same cycle.
- R10: `host_carry` equals C0, `host_parity` equals C2 and `host_zero` equals C3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_rpt | input | 6 | Exception report pulses, one bit per flag |
| stk_fault | input | 1 | Stack overflow/underflow report pulse |
| exc_clr | input | 1 | Clear exception flags, stack fault and summary |
| cw_load | input | 1 | Load control word |
| cw_wdata | input | 16 | Control word write data |
| cc_we | input | 1 | Condition code write enable |
| cc_in | input | 4 | Condition codes, bit n is Cn |
| top_we | input | 1 | Top-of-stack write enable |
| top_in | input | 3 | Top-of-stack pointer |
| busy_in | input | 1 | Busy indication from execution |
| sw_out | output | 16 | Status word read bus |
| cw_out | output | 16 | Control word read bus |
| host_carry | output | 1 | Host carry flag image (C0) |
| host_parity | output | 1 | Host parity flag image (C2) |
| host_zero | output | 1 | Host zero flag image (C3) |

## Verification
Some properties are checked on every cycle. The error summary can never be set with no flag set, and never with all masks set. Flags hold without a clear, every report lands, the stack fault never stands without the invalid flag, and the fixed control bits keep their values. Other behaviour only the bench scenarios show: that the summary follows a control load at the right moment, that a report wins over a simultaneous clear, and the exact placement of condition codes, top pointer and host flags.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;
   localparam int unsigned SW_W       = 16;
   localparam int unsigned NUM_EXC    = 6;
   localparam int unsigned TOP_BITS   = 3;
   localparam int unsigned BIT_IE     = 0;
   localparam int unsigned BIT_SF     = 6;
   localparam int unsigned BIT_ES     = 7;
   localparam int unsigned BIT_C0     = 8;
   localparam int unsigned BIT_C1     = 9;
   localparam int unsigned BIT_C2     = 10;
   localparam int unsigned BIT_TOP_LO = 11;
   localparam int unsigned BIT_C3     = 14;
   localparam int unsigned BIT_BUSY   = 15;

   typedef struct packed {
      logic c3;
      logic c2;
      logic c1;
      logic c0;
   } cc_t;
endpackage

// File: rtl/fes_sticky_bank.sv
module fes_sticky_bank #(
   parameter int unsigned EXC_W           = 6,
   parameter int unsigned INV_IDX         = 0,
   parameter bit          REPORT_OVER_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXC_W-1:0] rpt,
   input  logic             sf_rpt,
   input  logic             clr,
   output logic [EXC_W-1:0] flags_q,
   output logic             sf_q
);
   if (INV_IDX >= EXC_W) begin : g_bad_idx
      $error("fes_sticky_bank: INV_IDX out of range");
   end

   logic [EXC_W-1:0] set_vec;

   always_comb begin
      set_vec          = rpt;
      set_vec[INV_IDX] = rpt[INV_IDX] | sf_rpt;
   end

   for (genvar i = 0; i < EXC_W; i++) begin : g_cell
      logic nxt;
      if (REPORT_OVER_CLR) begin : g_rpt_wins
         assign nxt = (clr ? 1'b0 : flags_q[i]) | set_vec[i];
      end else begin : g_clr_wins
         assign nxt = clr ? 1'b0 : (flags_q[i] | set_vec[i]);
      end
      always_ff @(posedge clk) begin
         if (!rst_n) flags_q[i] <= 1'b0;
         else        flags_q[i] <= nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                            sf_q <= 1'b0;
      else if (sf_rpt && REPORT_OVER_CLR)    sf_q <= 1'b1;
      else if (clr)                          sf_q <= 1'b0;
      else if (sf_rpt)                       sf_q <= 1'b1;
   end

   // R2: a flag never drops without a clear
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // R2: every reported flag is set after the edge
   p_report_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (REPORT_OVER_CLR && (|rpt)) |=> ((flags_q & $past(rpt)) == $past(rpt)));

   // R3: stack fault implies invalid
   p_sf_implies_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sf_q |-> flags_q[INV_IDX]);
endmodule

// File: rtl/fes_ctrl_word.sv
module fes_ctrl_word #(
   parameter int unsigned CW_W     = 16,
   parameter logic [15:0] CW_RESET = 16'h037F,
   parameter logic [15:0] CW_WMASK = 16'h1F3F
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [CW_W-1:0] wdata,
   output logic [CW_W-1:0] cw_q
);
   if (CW_W != 16) begin : g_bad_w
      $error("fes_ctrl_word: CW_W must be 16");
   end

   localparam logic [CW_W-1:0] FIXED_MASK = ~CW_WMASK;
   localparam logic [CW_W-1:0] FIXED_VAL  = CW_RESET & FIXED_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n)    cw_q <= CW_RESET;
      else if (load) cw_q <= (wdata & CW_WMASK) | FIXED_VAL;
   end

   // R6: read-only bits keep their fixed value
   p_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_q & FIXED_MASK) == FIXED_VAL);

   // R6: no load, no change
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cw_q));
endmodule

// File: rtl/fes_status_pack.sv
module fes_status_pack
   import fpu_exc_pkg::*;
#(
   parameter int unsigned EXC_W = 6,
   parameter int unsigned TOP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXC_W-1:0] flags,
   input  logic [EXC_W-1:0] masks,
   input  logic             sf,
   input  cc_t              cc,
   input  logic [TOP_W-1:0] top,
   input  logic             busy,
   output logic [15:0]      sw
);
   if (EXC_W != NUM_EXC || TOP_W != TOP_BITS) begin : g_bad_layout
      $error("fes_status_pack: layout needs 6 flags and 3 top bits");
   end

   logic es;
   assign es = |(flags & ~masks);

   assign sw = {busy, cc.c3, top, cc.c2, cc.c1, cc.c0, es, sf, flags};

   // R4: summary needs an active flag
   p_es_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sw[BIT_ES] |-> (|flags));

   // R4: all masks set keeps summary low
   p_es_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (&masks) |-> !sw[BIT_ES]);
endmodule

// File: rtl/fpu_exc_status.sv
module fpu_exc_status
   import fpu_exc_pkg::*;
#(
   parameter int unsigned EXC_W           = 6,
   parameter int unsigned TOP_W           = 3,
   parameter logic [15:0] CW_RESET        = 16'h037F,
   parameter logic [15:0] CW_WMASK        = 16'h1F3F,
   parameter bit          REPORT_OVER_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXC_W-1:0] exc_rpt,
   input  logic             stk_fault,
   input  logic             exc_clr,
   input  logic             cw_load,
   input  logic [15:0]      cw_wdata,
   input  logic             cc_we,
   input  logic [3:0]       cc_in,
   input  logic             top_we,
   input  logic [TOP_W-1:0] top_in,
   input  logic             busy_in,
   output logic [15:0]      sw_out,
   output logic [15:0]      cw_out,
   output logic             host_carry,
   output logic             host_parity,
   output logic             host_zero
);
   logic [EXC_W-1:0] flags_q;
   logic             sf_q;
   cc_t              cc_q;
   logic [TOP_W-1:0] top_q;

   fes_sticky_bank #(
      .EXC_W(EXC_W), .INV_IDX(BIT_IE), .REPORT_OVER_CLR(REPORT_OVER_CLR)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .rpt(exc_rpt), .sf_rpt(stk_fault),
      .clr(exc_clr), .flags_q(flags_q), .sf_q(sf_q)
   );

   fes_ctrl_word #(
      .CW_W(16), .CW_RESET(CW_RESET), .CW_WMASK(CW_WMASK)
   ) u_cw (
      .clk(clk), .rst_n(rst_n), .load(cw_load), .wdata(cw_wdata), .cw_q(cw_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cc_q  <= '0;
         top_q <= '0;
      end else begin
         if (cc_we)  cc_q  <= cc_t'(cc_in);
         if (top_we) top_q <= top_in;
      end
   end

   fes_status_pack #(
      .EXC_W(EXC_W), .TOP_W(TOP_W)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .flags(flags_q), .masks(cw_out[EXC_W-1:0]),
      .sf(sf_q), .cc(cc_q), .top(top_q), .busy(busy_in), .sw(sw_out)
   );

   assign host_carry  = sw_out[BIT_C0];
   assign host_parity = sw_out[BIT_C2];
   assign host_zero   = sw_out[BIT_C3];

   // R7: condition codes hold without a write
   p_cc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cc_we |=> $stable({sw_out[BIT_C3], sw_out[BIT_C2:BIT_C0]}));

   // R8: top pointer holds without a write
   p_top_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !top_we |=> $stable(sw_out[BIT_TOP_LO +: TOP_W]));
endmodule

// File: tb/test_fpu_exc_status.sv
module test_fpu_exc_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  exc_rpt = '0;
   logic        stk_fault = 1'b0, exc_clr = 1'b0, cw_load = 1'b0;
   logic [15:0] cw_wdata = '0;
   logic        cc_we = 1'b0;
   logic [3:0]  cc_in = '0;
   logic        top_we = 1'b0;
   logic [2:0]  top_in = '0;
   logic        busy_in = 1'b0;
   logic [15:0] sw_out, cw_out;
   logic        host_carry, host_parity, host_zero;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fpu_exc_status i_fpu_exc_status (
      .clk(clk), .rst_n(rst_n), .exc_rpt(exc_rpt), .stk_fault(stk_fault),
      .exc_clr(exc_clr), .cw_load(cw_load), .cw_wdata(cw_wdata),
      .cc_we(cc_we), .cc_in(cc_in), .top_we(top_we), .top_in(top_in),
      .busy_in(busy_in), .sw_out(sw_out), .cw_out(cw_out),
      .host_carry(host_carry), .host_parity(host_parity), .host_zero(host_zero)
   );

   // {rpt[6], sf, clr, load, cw_wdata[16], exp_sw[16], exp_cw[16]}
   localparam int NV = 12;
   localparam logic [56:0] VEC [NV] = '{
      {6'b000001, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0001, 16'h037F}, // R2 IE
      {6'b000100, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0005, 16'h037F}, // R2 ZE added
      {6'b000000, 1'b0, 1'b0, 1'b1, 16'h037B, 16'h0085, 16'h037B}, // R4 unmask ZE
      {6'b000000, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h037B}, // R5 clear
      {6'b100000, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0020, 16'h037B}, // R5 report wins
      {6'b000000, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0061, 16'h037B}, // R3 stack fault
      {6'b000000, 1'b0, 1'b0, 1'b1, 16'hFFC0, 16'h00E1, 16'h1F40}, // R6 fixed bits
      {6'b001010, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h00EB, 16'h1F40}, // R2 OE+DE
      {6'b000000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h00EB, 16'h1F40}, // R2 hold
      {6'b000000, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h1F40}, // R5 clear all
      {6'b010000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0090, 16'h1F40}, // R4 UE unmasked
      {6'b000001, 1'b0, 1'b0, 1'b1, 16'h037F, 16'h0011, 16'h037F}  // R4 remask
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      exc_rpt = '0; stk_fault = 1'b0; exc_clr = 1'b0; cw_load = 1'b0;
      cc_we = 1'b0; top_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 sw", sw_out, 16'h0000);
      check("R1 cw", cw_out, 16'h037F);
      check("R1 host", {13'd0, host_carry, host_parity, host_zero}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         exc_rpt   = VEC[i][56:51];
         stk_fault = VEC[i][50];
         exc_clr   = VEC[i][49];
         cw_load   = VEC[i][48];
         cw_wdata  = VEC[i][47:32];
         @(negedge clk);
         idle_inputs();
         check($sformatf("vec%0d sw (R2..R6)", i), sw_out, VEC[i][31:16]);
         check($sformatf("vec%0d cw (R6)", i), cw_out, VEC[i][15:0]);
      end

      // R7/R10: C0 and C2 set
      cc_in = 4'b0101; cc_we = 1'b1;
      @(negedge clk); idle_inputs();
      check("R7 cc bits", sw_out & 16'h4700, 16'h0500);
      check("R10 host flags", {13'd0, host_carry, host_parity, host_zero}, 16'h0006);
      // R7: no write, codes hold
      cc_in = 4'b1010;
      @(negedge clk);
      check("R7 hold", sw_out & 16'h4700, 16'h0500);
      // R7/R10: C3 and C1
      cc_we = 1'b1;
      @(negedge clk); idle_inputs();
      check("R7 cc C3 C1", sw_out & 16'h4700, 16'h4200);
      check("R10 zero flag", {13'd0, host_carry, host_parity, host_zero}, 16'h0001);

      // R8: top pointer
      top_in = 3'd5; top_we = 1'b1;
      @(negedge clk); idle_inputs();
      check("R8 top", sw_out & 16'h3800, 16'h2800);
      top_in = 3'd2;
      @(negedge clk);
      check("R8 hold", sw_out & 16'h3800, 16'h2800);

      // R9: busy follows same cycle
      busy_in = 1'b1; #1;
      check("R9 busy set", sw_out & 16'h8000, 16'h8000);
      busy_in = 1'b0; #1;
      check("R9 busy clr", sw_out & 16'h8000, 16'h0000);

      // R4: unmask IE via load, summary appears with new cw
      cw_wdata = 16'h037E; cw_load = 1'b1;
      #1;
      check("R4 before edge", sw_out & 16'h0080, 16'h0000);
      @(negedge clk); idle_inputs();
      check("R4 after load", sw_out & 16'h0080, 16'h0080);

      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 re-reset sw", sw_out, 16'h0000);
      check("R1 re-reset cw", cw_out, 16'h037F);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule